// File: doc/BRIEF.md
# Vectored Interrupt Status Encoder

This block is the interrupt front end of one serial channel. Four request lines come in from the channel: transmit buffer empty, external/status change, receive character available and special receive condition. Each line is gated by its own enable. A master enable then decides whether the combined request reaches the interrupt request output. The receive enables are set through a two-bit receive mode. That mode can allow every received character, only the first character after the mode is written, or special conditions alone.

When the processor runs an interrupt acknowledge cycle, the block captures an 8-bit vector and holds it until the cycle ends. The vector comes from a programmable base. When the include-status control is set, bits 3:1 of the base are replaced by a code for the highest-priority enabled pending source. This lets one base value give a separate service entry for each source.

A small state machine drives the acknowledge handling. It has two states. In ST_IDLE it waits for acknowledge. The transition IDLE→HOLD happens on the first clock with acknowledge high, and the vector is captured on that edge. In ST_HOLD the vector is frozen. The transition HOLD→IDLE happens on the first clock with acknowledge low. In every other case the machine stays in its current state.

Top module: `isr_vector_unit`

## Requirements
- R1: A clocked write with `wr_en` high loads a setting register chosen by `wr_addr`:
  - address 0 is the base vector (all 8 bits).
  - address 1 holds the enables: bit 0 = external/status enable, bit 1 = transmit-empty enable, bits 3:2 = receive mode (00 off, 01 first character plus special, 10 every character plus special, 11 special only).
  - address 2 is the control: bit 0 = master enable, bit 1 = include status.
  - Address 3 is ignored.
- R2: `irq` is high one clock after an enabled source is pending while master enable is set. It is low one clock after no enabled source is pending.
- R3: `irq` stays low whenever master enable is clear, whatever the sources and enables.
- R4: With include-status clear, an acknowledge returns the base vector unchanged.
- R5: With include-status set, bits 3:1 of the returned vector hold the status code and the other bits come from the base. The codes are: 100 transmit empty, 101 external/status, 110 receive character, 111 special receive, 000 nothing pending. With base 0x20 this gives 0x28, 0x2A, 0x2C and 0x2E.
- R6: Disabling external/status or transmit-empty removes only that source. The receive sources are unaffected.
- R7: When several enabled sources are pending, the code selects, from highest to lowest priority: special receive, receive character, transmit empty, external/status.
- R8: The vector is captured on the first clock edge with `inta` high in ST_IDLE. It stays constant while `inta` remains high and is held until the next acknowledge. A new capture needs `inta` to go low first.
- R9: In receive mode 01, receive-character requests stop once one receive-character vector has been acknowledged. They resume when address 1 is written again. Special receive still requests.
- R10: Reset clears the base vector, all enables, master enable, include status, the captured vector and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Setting register write strobe |
| wr_addr | input | 2 | Setting register select |
| wr_data | input | 8 | Setting register write data |
| src_tx_empty | input | 1 | Transmit buffer empty request |
| src_ext_chg | input | 1 | External/status change request |
| src_rx_avail | input | 1 | Receive character available request |
| src_rx_special | input | 1 | Special receive condition request |
| inta | input | 1 | Interrupt acknowledge cycle active |
| irq | output | 1 | Interrupt request |
| vec_out | output | 8 | Captured interrupt vector |

## Verification
The bench runs the encoder with several kinds of input:
- Each source alone, which separates the four status codes.
- Nested sets of pending sources, which show that the priority order is obeyed rather than only the lowest or highest line.
- Base values with ones in the code field, which show that the replaced bits are cleared and the others kept.
- Cases with master enable clear, include status clear, single enables clear and the receive mode changed, which tell gating at the request line apart from gating in the vector.
- Directed runs that cover holding the vector while sources change during acknowledge, disarming in first-character mode, and reset.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int NSRC   = 4;
    localparam int CODE_W = 3;

    // source index doubles as priority rank: higher index wins
    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_TX   = 2'd1,
        SRC_RXAV = 2'd2,
        SRC_SPEC = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        RXM_OFF   = 2'b00,
        RXM_FIRST = 2'b01,
        RXM_ALL   = 2'b10,
        RXM_SPEC  = 2'b11
    } rxmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ack_state_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 3'b000;
    localparam logic [CODE_W-1:0] CODE_TX   = 3'b100;
    localparam logic [CODE_W-1:0] CODE_EXT  = 3'b101;
    localparam logic [CODE_W-1:0] CODE_RXAV = 3'b110;
    localparam logic [CODE_W-1:0] CODE_SPEC = 3'b111;

    localparam logic [1:0] ADDR_BASE = 2'd0;
    localparam logic [1:0] ADDR_ENA  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int ENA_EXT_BIT  = 0;
    localparam int ENA_TX_BIT   = 1;
    localparam int ENA_RXM_LSB  = 2;
    localparam int CTRL_MIE_BIT = 0;
    localparam int CTRL_VIS_BIT = 1;

    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            0:       return CODE_EXT;
            1:       return CODE_TX;
            2:       return CODE_RXAV;
            3:       return CODE_SPEC;
            default: return CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/isr_cfg_regs.sv
module isr_cfg_regs
    import isr_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic              clr_armed,
    output logic [VEC_W-1:0]  base_vec,
    output logic              mie,
    output logic              vis,
    output rxmode_e           rx_mode,
    output logic [NSRC-1:0]   src_en
);

    logic [VEC_W-1:0] base_q;
    logic             ext_en_q;
    logic             tx_en_q;
    rxmode_e          rxm_q;
    logic             mie_q;
    logic             vis_q;
    logic             armed_q;
    logic             ena_wr;

    assign ena_wr = wr_en && (wr_addr == ADDR_W'(ADDR_ENA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            ext_en_q <= 1'b0;
            tx_en_q  <= 1'b0;
            rxm_q    <= RXM_OFF;
            mie_q    <= 1'b0;
            vis_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADDR_BASE): base_q <= wr_data;
                ADDR_W'(ADDR_ENA): begin
                    ext_en_q <= wr_data[ENA_EXT_BIT];
                    tx_en_q  <= wr_data[ENA_TX_BIT];
                    rxm_q    <= rxmode_e'(wr_data[ENA_RXM_LSB +: 2]);
                end
                ADDR_W'(ADDR_CTRL): begin
                    mie_q <= wr_data[CTRL_MIE_BIT];
                    vis_q <= wr_data[CTRL_VIS_BIT];
                end
                default: ;
            endcase
        end
    end

    // first-character arming: set by any enable write, cleared when a
    // receive-character vector is handed out
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (ena_wr)
            armed_q <= 1'b1;
        else if (clr_armed)
            armed_q <= 1'b0;
    end

    always_comb begin
        src_en           = '0;
        src_en[SRC_EXT]  = ext_en_q;
        src_en[SRC_TX]   = tx_en_q;
        src_en[SRC_RXAV] = (rxm_q == RXM_ALL) || ((rxm_q == RXM_FIRST) && armed_q);
        src_en[SRC_SPEC] = (rxm_q != RXM_OFF);
    end

    assign base_vec = base_q;
    assign mie      = mie_q;
    assign vis      = vis_q;
    assign rx_mode  = rxm_q;

    AST_MIE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) |=> (mie_q == $past(wr_data[CTRL_MIE_BIT]))); // R1

endmodule

// File: rtl/isr_prio_arb.sv
module isr_prio_arb
    import isr_pkg::*;
(
    input  logic [NSRC-1:0]   src_raw,
    input  logic [NSRC-1:0]   src_en,
    output logic [NSRC-1:0]   grant,
    output logic [CODE_W-1:0] code,
    output logic              any_pend
);

    logic [NSRC-1:0] pend;

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign pend[g] = src_raw[g] & src_en[g];
    end

    // ascending scan: a later (higher) index overrides, giving fixed priority
    always_comb begin
        grant = '0;
        code  = CODE_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                code     = src_code(i);
            end
        end
    end

    assign any_pend = |pend;

endmodule

// File: rtl/isr_ack_seq.sv
module isr_ack_seq
    import isr_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int CODE_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inta,
    input  logic              any_pend,
    input  logic              mie,
    input  logic              vis,
    input  logic [VEC_W-1:0]  base_vec,
    input  logic [CODE_W-1:0] code,
    output logic              irq,
    output logic [VEC_W-1:0]  vec_out,
    output logic              ack_start
);

    localparam logic [VEC_W-1:0] CODE_MASK = VEC_W'(((1 << CODE_W) - 1) << CODE_LSB);

    ack_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] vec_d;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (inta)  state_d = ST_HOLD;
            ST_HOLD: if (!inta) state_d = ST_IDLE;
        endcase
    end

    assign ack_start = (state_q == ST_IDLE) && inta;

    always_comb begin
        if (vis)
            vec_d = (base_vec & ~CODE_MASK) | (VEC_W'(code) << CODE_LSB);
        else
            vec_d = base_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= mie && any_pend;
            if (ack_start)
                vec_q <= vec_d;
        end
    end

    assign irq     = irq_q;
    assign vec_out = vec_q;

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(vec_q)); // R8

    AST_HOLD_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !$past(inta)) |-> 1'b0 ); // R8

endmodule

// File: rtl/isr_vector_unit.sv
module isr_vector_unit
    import isr_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 2,
    parameter int CODE_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic              src_tx_empty,
    input  logic              src_ext_chg,
    input  logic              src_rx_avail,
    input  logic              src_rx_special,
    input  logic              inta,
    output logic              irq,
    output logic [VEC_W-1:0]  vec_out
);

    logic [VEC_W-1:0]  base_vec;
    logic              mie;
    logic              vis;
    rxmode_e           rx_mode;
    logic [NSRC-1:0]   src_en;
    logic [NSRC-1:0]   src_raw;
    logic [NSRC-1:0]   grant;
    logic [CODE_W-1:0] code;
    logic              any_pend;
    logic              ack_start;
    logic              clr_armed;

    always_comb begin
        src_raw           = '0;
        src_raw[SRC_EXT]  = src_ext_chg;
        src_raw[SRC_TX]   = src_tx_empty;
        src_raw[SRC_RXAV] = src_rx_avail;
        src_raw[SRC_SPEC] = src_rx_special;
    end

    assign clr_armed = ack_start && grant[SRC_RXAV];

    isr_cfg_regs #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clr_armed (clr_armed),
        .base_vec  (base_vec),
        .mie       (mie),
        .vis       (vis),
        .rx_mode   (rx_mode),
        .src_en    (src_en)
    );

    isr_prio_arb u_arb (
        .src_raw  (src_raw),
        .src_en   (src_en),
        .grant    (grant),
        .code     (code),
        .any_pend (any_pend)
    );

    isr_ack_seq #(.VEC_W(VEC_W), .CODE_LSB(CODE_LSB)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .inta      (inta),
        .any_pend  (any_pend),
        .mie       (mie),
        .vis       (vis),
        .base_vec  (base_vec),
        .code      (code),
        .irq       (irq),
        .vec_out   (vec_out),
        .ack_start (ack_start)
    );

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mie && any_pend) |=> irq); // R2

    AST_IRQ_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |=> !irq); // R3

    AST_PLAIN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && !vis) |=> (vec_out == $past(base_vec))); // R4

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7

    AST_SPECIAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && vis && src_rx_special && src_en[SRC_SPEC])
            |=> (vec_out[CODE_LSB +: CODE_W] == CODE_SPEC)); // R7

    AST_FIRST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && grant[SRC_RXAV] && rx_mode == RXM_FIRST
            && !(wr_en && wr_addr == ADDR_W'(ADDR_ENA))) |=> !src_en[SRC_RXAV]); // R9

endmodule

// File: tb/tb_isr_vector_unit.sv
module tb_isr_vector_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] src = '0;      // {special, rx char, tx empty, ext/status}
    logic       inta = 1'b0;
    logic       irq;
    logic [7:0] vec_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    isr_vector_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .src_tx_empty   (src[1]),
        .src_ext_chg    (src[0]),
        .src_rx_avail   (src[2]),
        .src_rx_special (src[3]),
        .inta           (inta),
        .irq            (irq),
        .vec_out        (vec_out)
    );

    // {enables, control, base, src, irq, vector}
    localparam int NROW = 19;
    localparam logic [36:0] TBL [NROW] = '{
        {8'h0B, 8'h03, 8'h20, 4'b0010, 1'b1, 8'h28},  // R5 tx
        {8'h0B, 8'h03, 8'h20, 4'b0001, 1'b1, 8'h2A},  // R5 ext
        {8'h0B, 8'h03, 8'h20, 4'b0100, 1'b1, 8'h2C},  // R5 rx char
        {8'h0B, 8'h03, 8'h20, 4'b1000, 1'b1, 8'h2E},  // R5 special
        {8'h0B, 8'h03, 8'h20, 4'b1111, 1'b1, 8'h2E},  // R7
        {8'h0B, 8'h03, 8'h20, 4'b0111, 1'b1, 8'h2C},  // R7
        {8'h0B, 8'h03, 8'h20, 4'b0011, 1'b1, 8'h28},  // R7
        {8'h0B, 8'h01, 8'h20, 4'b1000, 1'b1, 8'h20},  // R4
        {8'h0B, 8'h02, 8'h20, 4'b1111, 1'b0, 8'h2E},  // R3
        {8'h0A, 8'h03, 8'h20, 4'b0101, 1'b1, 8'h2C},  // R6
        {8'h0A, 8'h03, 8'h20, 4'b0001, 1'b0, 8'h20},  // R6
        {8'h09, 8'h03, 8'h20, 4'b0010, 1'b0, 8'h20},  // R6
        {8'h0B, 8'h03, 8'hF1, 4'b0100, 1'b1, 8'hFD},  // R5 base keeps other bits
        {8'h0B, 8'h01, 8'h57, 4'b0001, 1'b1, 8'h57},  // R4
        {8'h03, 8'h03, 8'h20, 4'b1100, 1'b0, 8'h20},  // R1 rx mode off
        {8'h0F, 8'h03, 8'h20, 4'b0100, 1'b0, 8'h20},  // R1 special only
        {8'h0F, 8'h03, 8'h20, 4'b1100, 1'b1, 8'h2E},  // R1 special only
        {8'h0B, 8'h03, 8'hA0, 4'b0000, 1'b0, 8'hA0},  // R5 none code
        {8'h09, 8'h03, 8'h20, 4'b0011, 1'b1, 8'h2A}   // R6 tx off, ext stays
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // call at a negedge; returns at a negedge with the write done
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [7:0] en, input logic [7:0] ctl, input logic [7:0] base);
        wr(2'd1, en);
        wr(2'd2, ctl);
        wr(2'd0, base);
    endtask

    task automatic ack_cycle(output logic [7:0] v);
        inta = 1'b1;
        @(negedge clk);
        v = vec_out;
        inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 irq in reset", {7'd0, irq}, 8'h00);
        check("R10 vector in reset", vec_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROW; i++) begin
            logic [36:0] row;
            row = TBL[i];
            setup(row[36:29], row[28:21], row[20:13]);
            src = row[12:9];
            @(negedge clk);
            check($sformatf("row %0d irq (R2 R3 R6 R1)", i), {7'd0, irq}, {7'd0, row[8]});
            ack_cycle(v);
            check($sformatf("row %0d vector (R4 R5 R7)", i), v, row[7:0]);
            src = 4'b0000;
            @(negedge clk);
        end

        // R2: request drops one clock after source clears
        setup(8'h0B, 8'h03, 8'h20);
        src = 4'b0010;
        @(negedge clk);
        check("R2 irq rises", {7'd0, irq}, 8'h01);
        src = 4'b0000;
        @(negedge clk);
        check("R2 irq falls", {7'd0, irq}, 8'h00);

        // R8: vector frozen during acknowledge, new capture after release
        src = 4'b0100;
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        check("R8 captured", vec_out, 8'h2C);
        src = 4'b1000;
        @(negedge clk);
        @(negedge clk);
        check("R8 held during ack", vec_out, 8'h2C);
        inta = 1'b0;
        @(negedge clk);
        check("R8 held after ack", vec_out, 8'h2C);
        inta = 1'b1;
        @(negedge clk);
        check("R8 new capture", vec_out, 8'h2E);
        inta = 1'b0;
        src = 4'b0000;
        @(negedge clk);

        // R9: first-character mode
        setup(8'h04, 8'h03, 8'h20);
        src = 4'b0100;
        @(negedge clk);
        check("R9 first char requests", {7'd0, irq}, 8'h01);
        ack_cycle(v);
        check("R9 first char vector", v, 8'h2C);
        check("R9 disarmed", {7'd0, irq}, 8'h00);
        ack_cycle(v);
        check("R9 disarmed vector", v, 8'h20);
        src = 4'b1100;
        @(negedge clk);
        check("R9 special still requests", {7'd0, irq}, 8'h01);
        src = 4'b0100;
        wr(2'd1, 8'h04);
        @(negedge clk);
        check("R9 rearmed", {7'd0, irq}, 8'h01);
        src = 4'b0000;
        @(negedge clk);

        // R10: reset mid-operation clears everything
        setup(8'h0B, 8'h03, 8'h20);
        src = 4'b1111;
        @(negedge clk);
        check("R10 pre-reset irq", {7'd0, irq}, 8'h01);
        ack_cycle(v);
        rst_n = 1'b0;
        #1;
        check("R10 irq cleared", {7'd0, irq}, 8'h00);
        check("R10 vector cleared", vec_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 master cleared", {7'd0, irq}, 8'h00);
        ack_cycle(v);
        check("R10 base and status cleared", v, 8'h00);
        src = 4'b0000;

        // R1: address 3 is ignored
        setup(8'h0B, 8'h01, 8'h44);
        wr(2'd3, 8'hFF);
        ack_cycle(v);
        check("R1 address 3 ignored", v, 8'h44);

        finish_run();
    end

endmodule